// File: doc/BRIEF.md
# Transmit Clock Loss and Receive Signal Loss Monitor

This block raises two independent alarms for a line interface. The first alarm watches a transmit clock. A free-running reference clock samples that clock, and the alarm fires when no level change arrives for a fixed number of reference cycles. This catches a clock stuck either high or low. The second alarm watches the two receive rails, which carry positive and negative marks. At each rising edge of the recovered receive bit clock the block samples both rails. The alarm fires when a long run of consecutive bits carries no mark on either rail.

Both alarms are active low and registered. Each releases as soon as its cause goes away. The clock alarm releases on the first observed transition of the monitored clock. The signal alarm releases on the first sampled bit that carries a mark. The monitored clock, the receive bit clock and the rails are all asynchronous to the reference clock. They pass through a shared multi-stage synchroniser before any decision is made.

Top module: `link_alarm_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both `tx_clk_lost_n` and `rx_sig_lost_n` are 1 (no alarm).
- R2: If `mon_clk` stays at 1, `tx_clk_lost_n` goes to 0 once CLK_LIMIT (default 24) reference cycles have passed with no synchronised transition. It stays at 0 while `mon_clk` stays stable.
- R3: The same alarm behaviour holds when `mon_clk` stays at 0.
- R4: A transition on `mon_clk`, driven before reference rising edge k, returns `tx_clk_lost_n` to 1 at edge k+2. This is SYNC_STAGES (2) synchroniser stages plus one. The alarm is still 0 after edge k+1.
- R5: A `mon_clk` that toggles with every level held for fewer than CLK_LIMIT reference cycles never asserts `tx_clk_lost_n`.
- R6: A bit is one rising edge of `rx_bit_clk`. After SIG_LIMIT (default 24) consecutive bits in which `rx_pos` and `rx_neg` are both 0, `rx_sig_lost_n` goes to 0.
- R7: A bit with `rx_pos`=1 or `rx_neg`=1 counts as a mark. A mark restarts the zero-run and releases `rx_sig_lost_n`. Either rail alone is enough.
- R8: The rails are sampled only at the rising edge of `rx_bit_clk`. A mark pulse that begins and ends while the bit clock is low has no effect on `rx_sig_lost_n`.
- R9: While `rx_bit_clk` does not rise, `rx_sig_lost_n` holds its value, whatever the rails do.
- R10: The two alarms are independent. A stuck `mon_clk` does not disturb `rx_sig_lost_n`, and receive activity does not disturb `tx_clk_lost_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Transmit clock under watch, asynchronous |
| rx_bit_clk | input | 1 | Recovered receive bit clock, asynchronous |
| rx_pos | input | 1 | Receive positive-mark rail |
| rx_neg | input | 1 | Receive negative-mark rail |
| tx_clk_lost_n | output | 1 | Active-low stuck transmit clock alarm |
| rx_sig_lost_n | output | 1 | Active-low receive loss-of-signal alarm |

## Verification
The assertions assume that each level of `mon_clk` and `rx_bit_clk` lasts at least one reference cycle. They also assume that the rails are steady when the bit clock rises, so that the bit clock and its rails reach the decision logic after the same synchroniser delay. The stimulus changes every input only at falling edges of the reference clock. The bit clock runs with a period of four reference cycles. New rail values are applied only when the bit clock falls. The deliberate mid-bit mark pulses are removed on the same edge at which the bit clock rises.

// File: rtl/link_alarm_pkg.sv
package link_alarm_pkg;

  // One reference-domain sample of every asynchronous input.
  typedef struct packed {
    logic mon;
    logic bclk;
    logic pos;
    logic neg;
  } line_sample_t;

  localparam int SAMPLE_W = $bits(line_sample_t);

  // A mark on either rail means the line carries signal.
  function automatic logic has_mark(line_sample_t s);
    return s.pos | s.neg;
  endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/transition_detect.sv
module transition_detect #(
  parameter bit RISING_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  generate
    if (RISING_ONLY) begin : g_rise
      assign pulse = sig & ~prev_q;
    end else begin : g_any
      assign pulse = sig ^ prev_q;
    end
  endgenerate

endmodule

// File: rtl/quiet_run_timer.sv
module quiet_run_timer #(
  parameter int CNT_W = 5,
  parameter int LIMIT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic alarm_n
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alarm_n_q;

  // Clear wins over advance; the count parks at the terminal value.
  always_comb begin
    cnt_d = cnt_q;
    if (clear)                       cnt_d = '0;
    else if (advance && cnt_q != TERM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      alarm_n_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      alarm_n_q <= (cnt_d != TERM);
    end
  end

  assign alarm_n = alarm_n_q;

endmodule

// File: rtl/link_alarm_monitor.sv
module link_alarm_monitor
  import link_alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5,
  parameter int CLK_LIMIT   = 24,
  parameter int SIG_LIMIT   = 24
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic mon_clk,
  input  logic rx_bit_clk,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic tx_clk_lost_n,
  output logic rx_sig_lost_n
);

  line_sample_t raw_s, sync_s;
  logic         mon_edge, bit_strobe, bit_mark;

  assign raw_s = '{mon: mon_clk, bclk: rx_bit_clk, pos: rx_pos, neg: rx_neg};

  // All four inputs share one synchroniser so rails and bit clock stay aligned.
  alarm_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (ref_clk),
    .rst (rst),
    .d   (raw_s),
    .q   (sync_s)
  );

  transition_detect #(.RISING_ONLY(1'b0)) u_clk_edge (
    .clk   (ref_clk),
    .rst   (rst),
    .sig   (sync_s.mon),
    .pulse (mon_edge)
  );

  transition_detect #(.RISING_ONLY(1'b1)) u_bit_edge (
    .clk   (ref_clk),
    .rst   (rst),
    .sig   (sync_s.bclk),
    .pulse (bit_strobe)
  );

  assign bit_mark = has_mark(sync_s);

  // Stuck-clock timer: counts every reference cycle, cleared by any edge.
  quiet_run_timer #(.CNT_W(CNT_W), .LIMIT(CLK_LIMIT)) u_clk_timer (
    .clk     (ref_clk),
    .rst     (rst),
    .clear   (mon_edge),
    .advance (1'b1),
    .alarm_n (tx_clk_lost_n)
  );

  // Zero-run timer: counts sampled bits, cleared by a marked bit.
  quiet_run_timer #(.CNT_W(CNT_W), .LIMIT(SIG_LIMIT)) u_sig_timer (
    .clk     (ref_clk),
    .rst     (rst),
    .clear   (bit_strobe & bit_mark),
    .advance (bit_strobe),
    .alarm_n (rx_sig_lost_n)
  );

endmodule

// File: rtl/link_alarm_monitor_chk.sv
module link_alarm_monitor_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_LIMIT   = 24,
  parameter int SIG_LIMIT   = 24
) (
  input logic ref_clk,
  input logic rst,
  input logic mon_clk,
  input logic rx_bit_clk,
  input logic rx_pos,
  input logic rx_neg,
  input logic tx_clk_lost_n,
  input logic rx_sig_lost_n
);

  logic [SYNC_STAGES-1:0] mon_p, bclk_p, pos_p, neg_p;
  logic                   mon_prev, bclk_prev, last_mark;
  logic [7:0]             quiet_cyc, zero_run;
  logic                   mon_d, bclk_d, mark_d, strobe_d;

  assign mon_d    = mon_p[SYNC_STAGES-1];
  assign bclk_d   = bclk_p[SYNC_STAGES-1];
  assign mark_d   = pos_p[SYNC_STAGES-1] | neg_p[SYNC_STAGES-1];
  assign strobe_d = bclk_d & ~bclk_prev;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      mon_p <= '0; bclk_p <= '0; pos_p <= '0; neg_p <= '0;
      mon_prev <= 1'b0; bclk_prev <= 1'b0; last_mark <= 1'b0;
      quiet_cyc <= '0; zero_run <= '0;
    end else begin
      mon_p  <= {mon_p[SYNC_STAGES-2:0], mon_clk};
      bclk_p <= {bclk_p[SYNC_STAGES-2:0], rx_bit_clk};
      pos_p  <= {pos_p[SYNC_STAGES-2:0], rx_pos};
      neg_p  <= {neg_p[SYNC_STAGES-2:0], rx_neg};
      mon_prev  <= mon_d;
      bclk_prev <= bclk_d;
      if (mon_d != mon_prev)    quiet_cyc <= '0;
      else if (quiet_cyc != 8'hFF) quiet_cyc <= quiet_cyc + 8'd1;
      if (strobe_d) begin
        last_mark <= mark_d;
        if (mark_d)                 zero_run <= '0;
        else if (zero_run != 8'hFF) zero_run <= zero_run + 8'd1;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(rst) |-> (tx_clk_lost_n && rx_sig_lost_n));

  // R2 R3
  clk_alarm_window_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(tx_clk_lost_n) |-> (quiet_cyc >= 8'(CLK_LIMIT)));

  // R2
  clk_alarm_hold_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!tx_clk_lost_n && mon_d == mon_prev) |=> !tx_clk_lost_n);

  // R4
  clk_release_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(tx_clk_lost_n) |-> (quiet_cyc <= 8'd1));

  // R6
  sig_alarm_window_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(rx_sig_lost_n) |-> (zero_run >= 8'(SIG_LIMIT)));

  // R7
  sig_release_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(rx_sig_lost_n) |-> last_mark);

  // R9
  sig_hold_idle_chk: assert property (@(posedge ref_clk) disable iff (rst)
    !strobe_d |=> $stable(rx_sig_lost_n));

endmodule

bind link_alarm_monitor link_alarm_monitor_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .CLK_LIMIT   (CLK_LIMIT),
  .SIG_LIMIT   (SIG_LIMIT)
) u_chk (.*);

// File: tb/link_alarm_monitor_tb.sv
module link_alarm_monitor_tb;

  localparam int LIMIT = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic mon = 1'b0, bclk = 1'b0, rp = 1'b0, rn = 1'b0;
  logic loc_n, los_n;

  always #4 clk = ~clk;

  link_alarm_monitor #(.SYNC_STAGES(2), .CNT_W(5), .CLK_LIMIT(LIMIT), .SIG_LIMIT(LIMIT)) u_dut (
    .ref_clk(clk), .rst(rst), .mon_clk(mon), .rx_bit_clk(bclk),
    .rx_pos(rp), .rx_neg(rn), .tx_clk_lost_n(loc_n), .rx_sig_lost_n(los_n)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  string req_c = "R1", req_s = "R1";

  // Expected-value model: inputs reach the decision logic after a two-stage
  // synchroniser; mh/bh hold the input values of the last three edges.
  logic       mh0, mh1, mh2;
  logic [2:0] bh0, bh1, bh2;   // {bit clock, pos, neg}
  int run_c = 0, run_s = 0;

  function automatic logic exp_alarm_n(int run);
    return run != LIMIT;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mh0 = 0; mh1 = 0; mh2 = 0; bh0 = 0; bh1 = 0; bh2 = 0;
      run_c = 0; run_s = 0;
    end else begin
      if (mh1 != mh2) run_c = 0;
      else if (run_c < LIMIT) run_c++;
      if (bh1[2] && !bh2[2]) begin
        if (bh1[1] | bh1[0]) run_s = 0;
        else if (run_s < LIMIT) run_s++;
      end
      mh2 = mh1; mh1 = mh0; mh0 = mon;
      bh2 = bh1; bh1 = bh0; bh0 = {bclk, rp, rn};
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Stimulus controls
  int  mon_half = 0, mon_cnt = 0, ph = 0, rail_mode = 0;
  bit  bit_run = 0, glitch = 0;

  task automatic step();
    @(negedge clk);
    check(req_c, "clock alarm", loc_n, exp_alarm_n(run_c));
    check(req_s, "signal alarm", los_n, exp_alarm_n(run_s));
    if (mon_half > 0) begin
      mon_cnt++;
      if (mon_cnt >= mon_half) begin mon = ~mon; mon_cnt = 0; end
    end
    if (bit_run) begin
      ph = (ph + 1) % 4;
      if (ph == 0) begin
        bclk = 1'b0;
        case (rail_mode)
          0: begin rp = 0; rn = 0; end
          1: begin
            automatic int r = int'($urandom % 16);
            rp = (r == 0); rn = (r == 1);
          end
          2: begin rp = 0; rn = 1; end
          default: begin rp = 1; rn = 0; end
        endcase
      end else if (ph == 1) begin
        if (glitch) rp = 1'b1;
      end else if (ph == 2) begin
        bclk = 1'b1;
        if (glitch) rp = 1'b0;
      end
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'd20250));
    // R1: reset state
    steps(4);
    check("R1", "clock alarm in reset", loc_n, 1'b1);
    check("R1", "signal alarm in reset", los_n, 1'b1);
    rst = 1'b0;
    step();
    check("R1", "clock alarm after reset", loc_n, 1'b1);
    check("R1", "signal alarm after reset", los_n, 1'b1);

    // R5 with R10: toggling clock, receive marks every bit
    req_c = "R5"; req_s = "R10";
    mon_half = 3; bit_run = 1; rail_mode = 3;
    steps(200);
    check("R5", "toggling clock no alarm", loc_n, 1'b1);
    mon_half = 23; steps(150);
    check("R5", "slow toggle below limit", loc_n, 1'b1);

    // R2: stuck high, receive active (R10)
    mon_half = 0; mon = 1'b1; req_c = "R2";
    steps(40);
    check("R2", "stuck high alarm", loc_n, 1'b0);
    check("R10", "signal alarm unaffected by stuck clock", los_n, 1'b1);

    // R4: single transition, exact release edge
    req_c = "R4";
    mon = 1'b0;
    steps(2);
    check("R4", "not released before sync", loc_n, 1'b0);
    step();
    check("R4", "released on transition", loc_n, 1'b1);

    // R3: stuck low
    req_c = "R3";
    steps(40);
    check("R3", "stuck low alarm", loc_n, 1'b0);

    // R6: all-zero bits while clock toggles (R10)
    mon_half = 5; req_c = "R10"; req_s = "R6";
    rail_mode = 0;
    steps(30 * 4);
    check("R6", "zero run alarm", los_n, 1'b0);
    check("R10", "clock alarm unaffected by zero run", loc_n, 1'b1);

    // R7: negative-rail mark releases, then positive-rail mark
    req_s = "R7";
    rail_mode = 2; steps(8);
    check("R7", "neg-rail mark release", los_n, 1'b1);
    rail_mode = 0; steps(30 * 4);
    check("R7", "re-assert after zeros", los_n, 1'b0);
    rail_mode = 3; steps(8);
    check("R7", "pos-rail mark release", los_n, 1'b1);
    rail_mode = 0; steps(30 * 4);

    // R8: mark pulses while bit clock low are ignored
    req_s = "R8"; glitch = 1;
    steps(12 * 4);
    check("R8", "mid-bit pulse ignored", los_n, 1'b0);
    glitch = 0;

    // R9: bit clock frozen low, rails show marks
    req_s = "R9"; bit_run = 0; bclk = 1'b0; rp = 1'b1; rn = 1'b1;
    steps(40);
    check("R9", "no strobe holds alarm", los_n, 1'b0);
    ph = 3; bit_run = 1; rail_mode = 3;
    steps(8);
    check("R9", "release after strobes resume", los_n, 1'b1);

    // Random mix: clock hold lengths around the limit, sparse marks
    req_c = "R2"; req_s = "R6"; mon_half = 0; rail_mode = 1;
    for (int k = 0; k < 60; k++) begin
      automatic int hold = int'($urandom_range(1, 36));
      steps(hold);
      mon = ~mon;
    end
    steps(10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule